// File: doc/BRIEF.md
# Byte-Mapped BCD Calendar Clock

This block keeps a 24-hour calendar in packed BCD (seconds, minutes, hours, day of week, date, month, two-digit year) and exposes it as the eight highest byte addresses of an 8K-byte memory window on a synchronous bus. A prescaler outside the block supplies a one-pulse-per-second tick and a raw oscillator tick; in return the block tells the prescaler whether the oscillator should run and drives a frequency-test square wave.

The time is held in two copies. Hidden working counters advance on the second tick. User-visible holding registers are what the bus reads and writes. While neither the freeze bit nor the load bit of the control byte is set, the holding registers follow the counters one cycle after every counter update. Freeze lets software take a consistent snapshot. Load lets it prepare a new time, and clearing load moves all seven bytes into the counters in one cycle. The oscillator stop flag sits in the seconds byte and the frequency-test flag sits in the day-of-week byte. Both act at once, whether or not a snapshot is held.

Top module: `bcd_calendar_regs`

## Requirements
- R1: The window is `bus_addr` 0x1FF8 to 0x1FFF, in rising order: control, seconds, minutes, hours, day of week, date, month, year. A read strobe registers the addressed byte onto `bus_rdata` at the next clock edge. A read of any address outside the window returns 0x00.
- R2: After reset the bytes read, in window order, 00, 00, 00, 00, 01, 01, 01, 00. `osc_run` is 1 and `ftest_out` is 0.
- R3: Each second tick increments the seconds. Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00, each wrap carrying into the next field.
- R4: An hours wrap advances the day of week, which wraps from 07 to 01.
- R5: An hours wrap advances the date. The date wraps to 01 after day 28 or 29 of month 02 (29 when the year value is divisible by 4), after day 30 of months 04, 06, 09 and 11, and after day 31 otherwise, carrying into the month. The month wraps from 12 to 01, carrying into the year, and the year wraps from 99 to 00.
- R6: While bit 6 of the control byte (freeze) is 1, the holding registers keep the time captured when freeze was set. Writing freeze back to 0 makes them show the current count again.
- R7: A freeze write that lands on the same clock edge as the holding-register update that follows a tick does not cancel that update. All seven bytes take the new time together.
- R8: While bit 7 of the control byte (load) is 1, ticks do not reach the holding registers. Writing load to 0 copies all seven holding bytes into the counters, and counting continues from those values.
- R9: With freeze and load both 0, a write to a time byte changes only the holding register. It reads back until the next tick's update overwrites it with the count.
- R10: Bit 7 of the seconds byte (stop) reads back as written. While it is 1, `osc_run` is 0 and the counters do not advance. Clearing it lets ticks count again.
- R11: While bit 6 of the day-of-week byte (test) is 1 and the oscillator runs, `ftest_out` and bit 0 of a seconds read show a square wave that toggles every 32 oscillator ticks (512 Hz from 32768 Hz). Otherwise `ftest_out` is 0 and seconds bit 0 is the stored value.
- R12: Bits fixed at zero read as 0 whatever was written: seconds and minutes bits 6:0 are stored, hours 5:0, day 2:0, date 5:0 and month 4:0. Control bits 5:0 (calibration sign and magnitude) are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second from the prescaler |
| osc_tick | input | 1 | One-cycle pulse per raw oscillator period |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| osc_run | output | 1 | Run enable to the prescaler |
| ftest_out | output | 1 | Frequency-test square wave |

## Verification
The bench drives the calendar across every rollover boundary. These include 28 February in common and leap years, the 29th of a leap February, the end of a 30-day month and the 99-to-00 year wrap. A wrong month-length table would land on a day that does not exist or skip a valid one. It times a freeze write to land on the same edge as the post-tick update. A design that let the freeze win would show the stale second. It also checks that a write made outside freeze is lost at the next tick, and that clearing load takes effect in the counters rather than only in the view. Random loaded times followed by random runs of ticks are compared with a bench calendar model. This catches carry-chain errors that the directed cases miss.

// File: rtl/cal_pkg.sv
// Package cal_pkg: shared types and BCD helper functions for the calendar
// clock. Assumes every time field is packed BCD, one byte per field.
package cal_pkg;
    localparam int NB     = 7;
    localparam int I_SEC  = 0;
    localparam int I_MIN  = 1;
    localparam int I_HR   = 2;
    localparam int I_DOW  = 3;
    localparam int I_DATE = 4;
    localparam int I_MON  = 5;
    localparam int I_YR   = 6;

    typedef logic [7:0]          byte_t;
    typedef byte_t [NB-1:0]      tvec_t;

    // Add one to a packed BCD byte.
    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Bits of each time byte that carry stored value.
    function automatic byte_t val_mask(input int idx);
        case (idx)
            I_SEC, I_MIN:   return 8'h7F;
            I_HR, I_DATE:   return 8'h3F;
            I_DOW:          return 8'h07;
            I_MON:          return 8'h1F;
            default:        return 8'hFF;
        endcase
    endfunction

    // True when a BCD year value is divisible by four.
    function automatic logic is_leap(input byte_t y);
        int b;
        b = int'(y[7:4]) * 10 + int'(y[3:0]);
        return (b % 4) == 0;
    endfunction

    // Last valid date (BCD) of a BCD month in a BCD year.
    function automatic byte_t month_end(input byte_t m, input byte_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Time value after reset: 00-01-01, day 1, 00:00:00.
    function automatic tvec_t reset_time();
        tvec_t v;
        v          = '0;
        v[I_DOW]   = 8'h01;
        v[I_DATE]  = 8'h01;
        v[I_MON]   = 8'h01;
        return v;
    endfunction
endpackage

// File: rtl/cal_counters.sv
// Module cal_counters: hidden working counters of the calendar. Advances
// one second per tick_en with the full carry chain. load_en replaces all
// seven bytes at once and takes priority over a tick in the same cycle.
// Assumes the loaded values have already been masked to their fields.
module cal_counters
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_en,
    input  logic  load_en,
    input  tvec_t load_val,
    output tvec_t cnt
);
    tvec_t nxt;
    logic  carry;

    // Compute the time one second after the current count.
    always_comb begin
        nxt   = cnt;
        carry = 1'b1;
        if (cnt[I_SEC] >= 8'h59) nxt[I_SEC] = 8'h00;
        else begin
            nxt[I_SEC] = bcd_inc(cnt[I_SEC]);
            carry      = 1'b0;
        end
        if (carry) begin
            if (cnt[I_MIN] >= 8'h59) nxt[I_MIN] = 8'h00;
            else begin
                nxt[I_MIN] = bcd_inc(cnt[I_MIN]);
                carry      = 1'b0;
            end
        end
        if (carry) begin
            if (cnt[I_HR] >= 8'h23) nxt[I_HR] = 8'h00;
            else begin
                nxt[I_HR] = bcd_inc(cnt[I_HR]);
                carry     = 1'b0;
            end
        end
        if (carry) begin
            nxt[I_DOW] = (cnt[I_DOW] >= 8'h07) ? 8'h01 : bcd_inc(cnt[I_DOW]);
            if (cnt[I_DATE] >= month_end(cnt[I_MON], cnt[I_YR])) nxt[I_DATE] = 8'h01;
            else begin
                nxt[I_DATE] = bcd_inc(cnt[I_DATE]);
                carry       = 1'b0;
            end
        end
        if (carry) begin
            if (cnt[I_MON] >= 8'h12) nxt[I_MON] = 8'h01;
            else begin
                nxt[I_MON] = bcd_inc(cnt[I_MON]);
                carry      = 1'b0;
            end
        end
        if (carry) begin
            nxt[I_YR] = (cnt[I_YR] >= 8'h99) ? 8'h00 : bcd_inc(cnt[I_YR]);
        end
    end

    // Register the counters: reset, load, or tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= reset_time();
        else if (load_en) cnt <= load_val;
        else if (tick_en) cnt <= nxt;
    end
endmodule

// File: rtl/cal_holding.sv
// Module cal_holding: user-visible holding registers. copy_en takes all
// seven counter bytes in one cycle and wins over a bus write in the same
// cycle. A bus write stores only the value bits of the addressed byte.
module cal_holding
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       copy_en,
    input  tvec_t      cnt,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  byte_t      wr_data,
    output tvec_t      hold
);
    localparam tvec_t RST = reset_time();

    for (genvar i = 0; i < NB; i++) begin : g_byte
        byte_t q;
        // Per-byte holding register: group copy first, then bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= RST[i];
            else if (copy_en)                          q <= cnt[i];
            else if (wr_en && (wr_idx == 3'(i)))       q <= wr_data & val_mask(i);
        end
        assign hold[i] = q;
    end
endmodule

// File: rtl/cal_ftest.sv
// Module cal_ftest: divides the raw oscillator tick down to a square wave
// that toggles every HALF ticks. Counts only while run is high. Assumes
// HALF is at least 2.
module cal_ftest #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run,
    output logic sq
);
    localparam int CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] div_q;

    // Divider counter and square-wave toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            sq    <= 1'b0;
        end else if (run && osc_tick) begin
            if (div_q == LAST) begin
                div_q <= '0;
                sq    <= ~sq;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_calendar_regs.sv
// Module bcd_calendar_regs: BCD calendar clock mapped into the top eight
// bytes of a byte-wide window. Holds control flags, decodes the bus and
// registers read data. Hidden counters and holding registers are kept in
// submodules. Assumes sec_tick and osc_tick are one-cycle pulses in the
// clk domain, and that the prescaler honours osc_run.
module bcd_calendar_regs
    import cal_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int OSC_HZ = 32768,
    parameter int FT_HZ  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              osc_run,
    output logic              ftest_out
);
    localparam int FT_HALF = OSC_HZ / (2 * FT_HZ);
    localparam logic [2:0] O_CTL = 3'd0;
    localparam logic [2:0] O_SEC = 3'd1;
    localparam logic [2:0] O_DOW = 3'd4;

    logic       in_win;
    logic [2:0] off;
    logic       wr_ctl, wr_time, load_rel, tick_en, copy_en;
    logic       load_q, freeze_q, stop_q, ft_q, upd_pend, resync;
    logic [5:0] cal_q;
    logic       sq;
    byte_t      rd_byte;
    tvec_t      cnt, hold;

    assign in_win   = &bus_addr[ADDR_W-1:3];
    assign off      = bus_addr[2:0];
    assign wr_ctl   = bus_wr && in_win && (off == O_CTL);
    assign wr_time  = bus_wr && in_win && (off != O_CTL);
    assign load_rel = wr_ctl && load_q && !bus_wdata[7];
    assign tick_en  = sec_tick && !stop_q && !load_rel;
    // Old freeze/load values gate the copy, so a same-edge freeze write
    // does not cancel an update already due.
    assign copy_en  = (upd_pend || resync) && !freeze_q && !load_q;

    // Control byte fields: load, freeze, calibration sign and magnitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= 1'b0;
            freeze_q <= 1'b0;
            cal_q    <= '0;
        end else if (wr_ctl) begin
            load_q   <= bus_wdata[7];
            freeze_q <= bus_wdata[6];
            cal_q    <= bus_wdata[5:0];
        end
    end

    // Stop and test flags live beside the seconds and day bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
        end else if (wr_time) begin
            if (off == O_SEC) stop_q <= bus_wdata[7];
            if (off == O_DOW) ft_q   <= bus_wdata[6];
        end
    end

    // Update requests: one after each counter step, one after a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pend <= 1'b0;
            resync   <= 1'b0;
        end else begin
            upd_pend <= tick_en;
            resync   <= wr_ctl;
        end
    end

    cal_counters u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_en  (load_rel),
        .load_val (hold),
        .cnt      (cnt)
    );

    cal_holding u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .copy_en (copy_en),
        .cnt     (cnt),
        .wr_en   (wr_time),
        .wr_idx  (off - 3'd1),
        .wr_data (bus_wdata),
        .hold    (hold)
    );

    cal_ftest #(.HALF(FT_HALF)) u_ft (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run      (!stop_q),
        .sq       (sq)
    );

    // Compose the addressed byte with flags and zero fields.
    always_comb begin
        case (off)
            O_CTL:   rd_byte = {load_q, freeze_q, cal_q};
            O_SEC:   rd_byte = {stop_q, hold[I_SEC][6:1],
                                (ft_q && !stop_q) ? sq : hold[I_SEC][0]};
            O_DOW:   rd_byte = {1'b0, ft_q, hold[I_DOW][5:0]};
            default: rd_byte = hold[off - 3'd1];
        endcase
    end

    // Registered read data; addresses outside the window read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= in_win ? rd_byte : 8'h00;
    end

    assign osc_run   = !stop_q;
    assign ftest_out = ft_q && !stop_q && sq;
endmodule

// File: rtl/cal_regs_chk.sv
// Module cal_regs_chk: temporal checks on the calendar clock, attached to
// every instance of the top by the bind below.
module cal_regs_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              osc_run,
    input logic              ftest_out,
    input logic [55:0]       cnt_v,
    input logic [55:0]       hold_v,
    input logic              freeze_q,
    input logic              load_q
);
    localparam logic [ADDR_W-1:0] CTL_A = {{(ADDR_W-3){1'b1}}, 3'b000};
    localparam logic [ADDR_W-1:0] SEC_A = CTL_A + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] HR_A  = CTL_A + ADDR_W'(3);

    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == CTL_A);

    AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEC_A && bus_wdata[7]) |=> !osc_run); // R10
    AST_STOPPED_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run && !ctl_wr) |=> $stable(cnt_v)); // R10
    AST_FTEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> !ftest_out); // R11
    AST_FROZEN_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !bus_wr) |=> $stable(hold_v)); // R6
    AST_LOAD_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && load_q && !bus_wdata[7]) |=> (cnt_v == $past(hold_v))); // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && osc_run && !ctl_wr && cnt_v[7:0] == 8'h59) |=> (cnt_v[7:0] == 8'h00)); // R3
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && osc_run && !ctl_wr && cnt_v[31:0] == 32'h07235959) |=> (cnt_v[31:24] == 8'h01)); // R4
    AST_HOUR_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == HR_A) |=> (bus_rdata[7:6] == 2'b00)); // R12
endmodule

bind bcd_calendar_regs cal_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .osc_run   (osc_run),
    .ftest_out (ftest_out),
    .cnt_v     (cnt),
    .hold_v    (hold),
    .freeze_q  (freeze_q),
    .load_q    (load_q)
);

// File: tb/bcd_calendar_regs_test.sv
// Bench for bcd_calendar_regs: directed rollover and control cases plus
// random loaded times, checked against a calendar model kept in the bench.
module bcd_calendar_regs_test;
    localparam logic [12:0] A_CTL = 13'h1FF8;
    localparam logic [12:0] A_SEC = 13'h1FF9;
    localparam logic [12:0] A_MIN = 13'h1FFA;
    localparam logic [12:0] A_HR  = 13'h1FFB;
    localparam logic [12:0] A_DOW = 13'h1FFC;
    localparam logic [12:0] A_DAT = 13'h1FFD;
    localparam logic [12:0] A_MON = 13'h1FFE;
    localparam logic [12:0] A_YR  = 13'h1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        osc_run;
    logic        ftest_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    int n_osc = 0;

    always #10 clk = ~clk;

    bcd_calendar_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .osc_tick  (osc_tick),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .osc_run   (osc_run),
        .ftest_out (ftest_out)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date <= mdays(m_mon, m_yr)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1;
        m_yr = (m_yr + 1) % 100;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // One second tick, then one idle cycle for the holding update.
    task automatic tick(input bit running);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
        if (running) model_step();
    endtask

    task automatic set_time(input int yr, mon, date, dow, hr, mi, se);
        do_write(A_CTL, 8'h80);
        do_write(A_SEC, to_bcd(se));
        do_write(A_MIN, to_bcd(mi));
        do_write(A_HR,  to_bcd(hr));
        do_write(A_DOW, to_bcd(dow));
        do_write(A_DAT, to_bcd(date));
        do_write(A_MON, to_bcd(mon));
        do_write(A_YR,  to_bcd(yr));
        do_write(A_CTL, 8'h00);
        @(negedge clk);
        @(negedge clk);
        m_yr = yr; m_mon = mon; m_date = date; m_dow = dow;
        m_hr = hr; m_min = mi; m_sec = se;
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        do_read(A_SEC, d); check({req, " seconds"}, d, to_bcd(m_sec));
        do_read(A_MIN, d); check({req, " minutes"}, d, to_bcd(m_min));
        do_read(A_HR,  d); check({req, " hours"},   d, to_bcd(m_hr));
        do_read(A_DOW, d); check({req, " day"},     d, to_bcd(m_dow));
        do_read(A_DAT, d); check({req, " date"},    d, to_bcd(m_date));
        do_read(A_MON, d); check({req, " month"},   d, to_bcd(m_mon));
        do_read(A_YR,  d); check({req, " year"},    d, to_bcd(m_yr));
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] snap;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        m_yr = 0; m_mon = 1; m_date = 1; m_dow = 1; m_hr = 0; m_min = 0; m_sec = 0;
        do_read(A_CTL, d); check("R2 control", d, 8'h00);
        check_all("R2 reset");
        check("R2 osc_run", osc_run, 1);
        check("R2 ftest_out", ftest_out, 0);

        // R1: outside the window reads zero
        do_read(13'h0100, d); check("R1 outside window", d, 8'h00);
        do_read(13'h1FF7, d); check("R1 below window", d, 8'h00);

        // R3: seconds/minutes/hours wrap
        set_time(45, 6, 14, 3, 23, 59, 58);
        check_all("R1 loaded order");
        tick(1); tick(1);
        check_all("R3 hour wrap");

        // R4: day of week 7 -> 1
        set_time(10, 3, 10, 7, 23, 59, 59);
        tick(1);
        check_all("R4 dow wrap");

        // R5: month lengths and year wrap
        set_time(23, 2, 28, 2, 23, 59, 59); tick(1); check_all("R5 common feb");
        set_time(24, 2, 28, 2, 23, 59, 59); tick(1); check_all("R5 leap feb 28");
        set_time(24, 2, 29, 2, 23, 59, 59); tick(1); check_all("R5 leap feb 29");
        set_time(31, 4, 30, 5, 23, 59, 59); tick(1); check_all("R5 april end");
        set_time(99, 12, 31, 6, 23, 59, 59); tick(1); check_all("R5 year wrap");

        // R6: freeze holds snapshot
        set_time(50, 8, 8, 4, 10, 20, 30);
        do_write(A_CTL, 8'h40);
        snap = to_bcd(m_sec);
        tick(1); tick(1); tick(1);
        do_read(A_SEC, d); check("R6 frozen seconds", d, snap);
        do_write(A_CTL, 8'h00);
        @(negedge clk);
        check_all("R6 after unfreeze");

        // R7: freeze on the same edge as the update
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_wr = 1'b1; bus_addr = A_CTL; bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        model_step();
        snap = to_bcd(m_sec);
        do_read(A_SEC, d); check("R7 update completes", d, snap);
        tick(1);
        do_read(A_SEC, d); check("R7 then frozen", d, snap);
        do_write(A_CTL, 8'h00);
        @(negedge clk);

        // R8: load halts copy; release moves bytes into counters
        do_write(A_CTL, 8'h80);
        do_write(A_SEC, 8'h10);
        tick(0); tick(0);
        do_read(A_SEC, d); check("R8 load view kept", d, 8'h10);
        do_write(A_CTL, 8'h00);
        @(negedge clk);
        m_sec = 10;
        do_read(A_SEC, d); check("R8 transferred", d, 8'h10);
        tick(1);
        check_all("R8 counts from loaded");

        // R9: unfrozen write is overwritten by next update
        do_write(A_MIN, 8'h33);
        do_read(A_MIN, d); check("R9 write visible", d, 8'h33);
        tick(1);
        do_read(A_MIN, d); check("R9 overwritten", d, to_bcd(m_min));

        // R10: stop bit
        do_write(A_SEC, 8'h80 | to_bcd(m_sec));
        check("R10 osc_run low", osc_run, 0);
        tick(0); tick(0); tick(0);
        do_read(A_SEC, d); check("R10 stop readback", d, 8'h80 | to_bcd(m_sec));
        do_write(A_SEC, to_bcd(m_sec));
        check("R10 osc_run high", osc_run, 1);
        tick(1);
        check_all("R10 resumes");

        // R11: frequency test square wave
        do_write(A_DOW, 8'h40 | to_bcd(m_dow));
        @(negedge clk);
        osc_tick = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            n_osc++;
            check("R11 ftest_out", ftest_out, (n_osc / 32) % 2);
        end
        osc_tick = 1'b0;
        do_read(A_SEC, d);
        check("R11 seconds bit0", d, (to_bcd(m_sec) & 8'hFE) | 8'((n_osc / 32) % 2));
        do_read(A_DOW, d); check("R11 test flag readback", d, 8'h40 | to_bcd(m_dow));
        do_write(A_DOW, to_bcd(m_dow));
        check("R11 ftest off", ftest_out, 0);
        do_read(A_SEC, d); check("R11 seconds normal", d, to_bcd(m_sec));

        // R12: zero fields and calibration readback
        do_write(A_CTL, 8'h6A);
        do_write(A_HR, 8'hFF);
        do_write(A_MON, 8'hFF);
        do_write(A_DAT, 8'hFF);
        do_read(A_HR, d);  check("R12 hours mask", d, 8'h3F);
        do_read(A_MON, d); check("R12 month mask", d, 8'h1F);
        do_read(A_DAT, d); check("R12 date mask", d, 8'h3F);
        do_read(A_CTL, d); check("R12 calibration", d, 8'h6A);
        do_write(A_CTL, 8'h00);
        @(negedge clk);
        check_all("R12 restored");

        // R3 R5: random loaded times and random tick runs
        for (int it = 0; it < 20; it++) begin
            int yr, mo, dt, n;
            yr = int'($urandom_range(0, 99));
            mo = int'($urandom_range(1, 12));
            dt = int'($urandom_range(1, mdays(mo, yr)));
            set_time(yr, mo, dt, int'($urandom_range(1, 7)), int'($urandom_range(20, 23)),
                     int'($urandom_range(55, 59)), int'($urandom_range(0, 59)));
            n = int'($urandom_range(1, 300));
            for (int t = 0; t < n; t++) tick(1);
            check_all("R5 random run");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule